// File: doc/BRIEF.md
# Serial Control-Port Register Loader

This block is a control-port slave that lets a host processor load a small bank of byte-wide settings registers over a four-wire serial link: an active-low select, a bit clock, a serial data input and a serial data output. All four pins are brought into the block's own system clock domain through synchronizers. Edges of the bit clock are detected there, so the host clock can be fully asynchronous to the system clock, provided each bit-clock phase lasts several system clocks.

A transfer opens when the select goes low. The host first sends a 7-bit device address and a direction bit. For a write, the next byte is a pointer byte, which chooses the target register and can switch on pointer auto-increment. It is followed by one or more data bytes. For a read, the register at the current pointer is shifted out on the data output straight after the address byte. The select pin doubles as a strap input on boards that do not use this serial mode. For that reason the port stays inert until it sees the first high-to-low transition on the select pin after reset. From then on it stays in serial mode until the next reset.

Top module: `spi_ctl_port`

## Requirements
- R1: After reset every register in `regs_flat` reads 0x00, `spi_mode` is 0 and `sdo_oe` is 0.
- R2: `spi_mode` rises only after a high-to-low transition of `cs_n` following reset, and then stays 1 until reset. While it is 0, clocking bytes in with `cs_n` held low changes no register. A falling edge is needed: a pin held steadily low or high from reset never sets the flag.
- R3: `sdi` is sampled on rising edges of `sclk`, most significant bit first. The first seven bits must equal the device address 0010000 (so byte 0x20 opens a write and 0x21 opens a read). The eighth bit is the direction: 0 for a write, 1 for a read.
- R4: In a write transfer, the byte after the address byte is the pointer byte. Its bits 2..0 select the register, bit 7 enables auto-increment, and bits 6..3 are ignored. The byte after it is stored in the selected register.
- R5: With auto-increment set, each further data byte in the same transfer goes to the next register address, wrapping from 7 to 0.
- R6: With auto-increment clear, further data bytes in the same transfer all overwrite the same register.
- R7: Raising `cs_n` ends the transfer. A partially received byte is discarded without a write, and the next transfer starts from bit 0 of a new address byte.
- R8: If the address does not match, no register changes for the rest of that transfer, even if a valid address byte follows inside it. `sdo_oe` stays 0 until `cs_n` rises.
- R9: Register 0 and registers above `LAST_REG` (register 7 by default) ignore writes, and both `regs_flat` and read transfers show them as 0x00.
- R10: In a read transfer, `sdo_oe` is 0 during the address byte and 1 from the following falling edge of `sclk` while `cs_n` stays low. The register at the pointer is driven MSB first, with a new bit after each falling edge. With auto-increment set, successive bytes come from successive registers.
- R11: The pointer and auto-increment setting persist across transfers. A write transfer carrying only the address and pointer bytes sets the register that a later read transfer returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select, shared with the strap function |
| sclk | input | 1 | Serial bit clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means the pad is high-impedance |
| spi_mode | output | 1 | Sticky serial-mode flag |
| regs_flat | output | 8*2^PTR_W | Register bank contents, register i at bits [8i+7:8i] |

## Verification
Writes are tried with single bytes, with reserved pointer bits set, with auto-increment bursts that cross the top of the pointer range, and with repeated bytes without auto-increment. Comparing which registers changed separates correct pointer handling from wrong increment, missing wrap or decoding of the reserved bits. Transfers cut short mid-byte, and transfers with a wrong address that is later followed by a correct-looking byte, show whether partial data is thrown away and whether the port falsely resynchronises. Reads are done after pointer-only transfers and in bursts. These compare the shifted bits and the enable timing against the stored values, which exposes bit-order, edge-choice and pointer-persistence faults. Clocking bytes with the select held low or high from reset tells the strap behaviour apart from a simple level test.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    PH_ADDR,
    PH_MAP,
    PH_DATA,
    PH_READ,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_ctl_regfile.sv
module spi_ctl_regfile
  import spi_ctl_pkg::*;
#(
  parameter int PTR_W    = 3,
  parameter int LAST_REG = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [PTR_W-1:0]               wr_addr,
  input  logic [BYTE_W-1:0]              wr_data,
  input  logic [PTR_W-1:0]               rd_addr,
  output logic [BYTE_W-1:0]              rd_data,
  output logic [BYTE_W*(1<<PTR_W)-1:0]   regs_flat
);
  localparam int NUM_REGS = 1 << PTR_W;

  logic [BYTE_W-1:0] mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i >= 1 && i <= LAST_REG) begin : g_impl
      logic [BYTE_W-1:0] val_q;
      logic              val_en;
      assign val_en = wr_en && (wr_addr == PTR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      val_q <= '0;
        else if (val_en) val_q <= wr_data;
      end
      assign mem[i] = val_q;
    end else begin : g_none
      assign mem[i] = '0;
    end
    assign regs_flat[i*BYTE_W +: BYTE_W] = mem[i];
  end

  assign rd_data = mem[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= PTR_W'(1) && int'(wr_addr) <= LAST_REG)
      |=> mem[$past(wr_addr)] == $past(wr_data)); // R4
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat)); // R7
endmodule

// File: rtl/spi_ctl_frame.sv
module spi_ctl_frame
  import spi_ctl_pkg::*;
#(
  parameter int                PTR_W    = 3,
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'b0010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cs_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  rd_addr,
  output logic              sdo,
  output logic              sdo_oe
);
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              incr_q, incr_d;
  logic [BYTE_W-1:0] byte_full;
  logic              last_bit;

  assign byte_full = {sh_q[BYTE_W-2:0], sdi_s};
  assign last_bit  = (bit_q == CNT_W'(BYTE_W-1));

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    out_d   = out_q;
    ptr_d   = ptr_q;
    incr_d  = incr_q;
    wr_en   = 1'b0;
    if (!en || cs_s) begin
      phase_d = PH_ADDR;
      bit_d   = '0;
      sh_d    = '0;
      out_d   = '0;
    end else begin
      if (sclk_rise) begin
        sh_d  = byte_full;
        bit_d = bit_q + 1'b1;
        if (last_bit) begin
          unique case (phase_q)
            PH_ADDR: begin
              if (sh_q[BYTE_W-2:0] != DEV_ADDR) phase_d = PH_SKIP;
              else if (sdi_s)                   phase_d = PH_READ;
              else                              phase_d = PH_MAP;
            end
            PH_MAP: begin
              ptr_d   = byte_full[PTR_W-1:0];
              incr_d  = byte_full[BYTE_W-1];
              phase_d = PH_DATA;
            end
            PH_DATA: begin
              wr_en = 1'b1;
              if (incr_q) ptr_d = ptr_q + 1'b1;
            end
            PH_READ: begin
              if (incr_q) ptr_d = ptr_q + 1'b1;
            end
            default: ;
          endcase
        end
      end
      if (sclk_fall && phase_q == PH_READ) begin
        if (bit_q == '0) out_d = rd_data;
        else             out_d = {out_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ADDR;
      bit_q   <= '0;
      sh_q    <= '0;
      out_q   <= '0;
      ptr_q   <= PTR_W'(1);
      incr_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      out_q   <= out_d;
      ptr_q   <= ptr_d;
      incr_q  <= incr_d;
    end
  end

  assign wr_addr = ptr_q;
  assign wr_data = byte_full;
  assign rd_addr = ptr_q;
  assign sdo     = out_q[BYTE_W-1];
  assign sdo_oe  = en && !cs_s && (phase_q == PH_READ);

  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (phase_q == PH_ADDR && bit_q == '0)); // R7
  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cs_s && phase_q == PH_SKIP) |=> (phase_q == PH_SKIP && !wr_en)); // R8
  AST_SDO_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !cs_s && phase_q == PH_READ) |=> $stable(sdo)); // R10
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && incr_q) |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1)); // R5
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int                PTR_W       = 3,
  parameter int                LAST_REG    = 6,
  parameter logic [BYTE_W-2:0] DEV_ADDR    = 7'b0010000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         sclk,
  input  logic                         sdi,
  output logic                         sdo,
  output logic                         sdo_oe,
  output logic                         spi_mode,
  output logic [BYTE_W*(1<<PTR_W)-1:0] regs_flat
);
  logic [1:0]        rst_sh;
  logic              rst_i_n;
  logic [2:0]        pins_s;
  logic              cs_s, sclk_s, sdi_s;
  logic              cs_prev, sclk_prev;
  logic              sclk_rise, sclk_fall, cs_fall;
  logic              mode_q, mode_d;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_i_n = rst_sh[1];

  spi_ctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     ({cs_n, sclk, sdi}),
    .q     (pins_s)
  );
  assign {cs_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cs_prev   <= 1'b0;
      sclk_prev <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      cs_prev   <= cs_s;
      sclk_prev <= sclk_s;
      mode_q    <= mode_d;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;
  assign cs_fall   = cs_prev & ~cs_s;

  always_comb begin
    mode_d = mode_q;
    if (cs_fall) mode_d = 1'b1;
  end

  spi_ctl_frame #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .en        (mode_q),
    .cs_s      (cs_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .sdi_s     (sdi_s),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

  spi_ctl_regfile #(.PTR_W(PTR_W), .LAST_REG(LAST_REG)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .regs_flat (regs_flat)
  );

  assign spi_mode = mode_q;

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    mode_q |=> mode_q); // R2
  AST_MODE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(mode_q) |-> ($past(cs_prev) && !$past(cs_s))); // R2
  AST_NO_WRITE_UNMODED: assert property (@(posedge clk) disable iff (!rst_i_n)
    !mode_q |-> (!wr_en && !sdo_oe)); // R2
endmodule

// File: tb/spi_ctl_port_bench.sv
module spi_ctl_port_bench;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, sdi;
  logic        sdo, sdo_oe, spi_mode;
  logic [63:0] regs_flat;
  logic [7:0]  exp_r [8];
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  spi_ctl_port u_spi_ctl_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .spi_mode(spi_mode), .regs_flat(regs_flat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < 8; i++) chk(tag, regs_flat[i*8 +: 8], exp_r[i]);
  endtask

  task automatic do_reset(input logic cs_level);
    rst_n = 1'b0; cs_n = cs_level; sclk = 1'b0; sdi = 1'b0;
    for (int i = 0; i < 8; i++) exp_r[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oe_all, output logic oe_any);
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; sdi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = sdo; oe_all &= sdo_oe; oe_any |= sdo_oe;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic wb(input logic [7:0] tx);
    logic [7:0] rx; logic a, o;
    xfer(tx, rx, a, o);
  endtask

  task automatic start_f();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_f();
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic put(input int r, input logic [7:0] v);
    if (r >= 1 && r <= 6) exp_r[r] = v;
  endtask

  task automatic t_reset_and_strap();
    do_reset(1'b0);
    chk("R1 spi_mode after reset", spi_mode, 0);
    chk("R1 sdo_oe after reset", sdo_oe, 0);
    chk_regs("R1 regs after reset");
    wb(8'h20); wb(8'h02); wb(8'hAA);
    sclk = 1'b0; repeat (HALF) @(negedge clk);
    chk("R2 no mode with pin held low", spi_mode, 0);
    chk_regs("R2 no write before mode");
    cs_n = 1'b1; repeat (2*HALF) @(negedge clk);
    chk("R2 rising pin does not set mode", spi_mode, 0);
    cs_n = 1'b0; repeat (HALF) @(negedge clk);
    chk("R2 mode set by falling pin", spi_mode, 1);
    cs_n = 1'b1; repeat (2*HALF) @(negedge clk);
    chk("R2 mode sticky", spi_mode, 1);
  endtask

  task automatic t_single_write();
    start_f(); wb(8'h20); wb(8'h02); wb(8'h3C); end_f();
    put(2, 8'h3C);
    chk_regs("R3 R4 single write reg2");
    start_f(); wb(8'h20); wb(8'h7B); wb(8'hC5); end_f();
    put(3, 8'hC5);
    chk_regs("R4 reserved pointer bits ignored");
  endtask

  task automatic t_burst();
    start_f(); wb(8'h20); wb(8'h85);
    wb(8'h11); wb(8'h22); wb(8'h77); wb(8'h88); wb(8'h55);
    end_f();
    put(5, 8'h11); put(6, 8'h22); put(1, 8'h55);
    chk_regs("R5 burst with wrap");
  endtask

  task automatic t_no_incr();
    start_f(); wb(8'h20); wb(8'h04); wb(8'h01); wb(8'h02); end_f();
    put(4, 8'h02);
    chk_regs("R6 repeated bytes same register");
  endtask

  task automatic t_abort();
    logic [7:0] rx; logic a, o;
    start_f(); wb(8'h20); wb(8'h04);
    for (int i = 7; i >= 4; i--) begin
      sclk = 1'b0; sdi = 1'b1; repeat (HALF) @(negedge clk);
      sclk = 1'b1; repeat (HALF) @(negedge clk);
    end
    end_f();
    chk_regs("R7 partial byte discarded");
    start_f(); xfer(8'h20, rx, a, o); wb(8'h04); wb(8'h99); end_f();
    put(4, 8'h99);
    chk_regs("R7 next frame restarts at bit 0");
  endtask

  task automatic t_mismatch();
    logic [7:0] rx; logic a, o;
    start_f(); wb(8'h22); wb(8'h02); wb(8'hFF); end_f();
    chk_regs("R8 wrong address no write");
    start_f(); wb(8'h24); wb(8'h20); wb(8'h02); wb(8'hEE); end_f();
    chk_regs("R8 no resync inside frame");
    start_f(); xfer(8'h23, rx, a, o); xfer(8'h00, rx, a, o); end_f();
    chk("R8 sdo_oe low after wrong read address", o, 0);
  endtask

  task automatic t_unimpl();
    logic [7:0] rx; logic a, o;
    start_f(); wb(8'h20); wb(8'h00); wb(8'hA5); end_f();
    start_f(); wb(8'h20); wb(8'h07); wb(8'h5A); end_f();
    chk_regs("R9 reg0 and reg7 ignore writes");
    start_f(); xfer(8'h21, rx, a, o); xfer(8'h00, rx, a, o); end_f();
    chk("R9 reg7 reads zero", rx, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] rx; logic a, o;
    start_f(); wb(8'h20); wb(8'h02); end_f();
    chk_regs("R11 pointer-only frame writes nothing");
    start_f();
    xfer(8'h21, rx, a, o);
    chk("R10 sdo_oe low during address byte", o, 0);
    xfer(8'h00, rx, a, o);
    end_f();
    chk("R11 read uses stored pointer", rx, exp_r[2]);
    chk("R10 sdo_oe high during read byte", a, 1);
    chk("R10 sdo_oe released after frame", sdo_oe, 0);
    start_f(); wb(8'h20); wb(8'h82); end_f();
    start_f(); xfer(8'h21, rx, a, o);
    xfer(8'h00, rx, a, o); chk("R10 burst read byte0", rx, exp_r[2]);
    xfer(8'h00, rx, a, o); chk("R10 burst read byte1", rx, exp_r[3]);
    xfer(8'h00, rx, a, o); chk("R10 burst read byte2", rx, exp_r[4]);
    end_f();
  endtask

  task automatic t_rereset();
    do_reset(1'b1);
    chk("R1 spi_mode cleared by reset", spi_mode, 0);
    chk_regs("R1 regs cleared by reset");
    repeat (40) @(negedge clk);
    chk("R2 pin held high keeps mode off", spi_mode, 0);
  endtask

  initial begin
    t_reset_and_strap();
    t_single_write();
    t_burst();
    t_no_incr();
    t_abort();
    t_mismatch();
    t_unimpl();
    t_read();
    t_rereset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule